// File: doc/BRIEF.md
# Receive Character Buffer with Ageing Timeout

This block sits between the receive shifter of a memory-mapped serial port and the register interface that software reads. Each character the shifter delivers carries its own parity and framing error flags. The block stores it as one word in a first-in first-out queue, which holds 32 entries by default. A line-break event is stored in the same queue as a word of its own. A pop request returns the oldest stored word with a valid marker set. A pop of an empty queue returns an all-zero word.

The status logic keeps two level flags and three sticky bits. The receive-ready level flag is compared against a programmable trigger level, and the data-ready level flag shows that the queue holds data. The sticky bits record an overrun, an ageing timeout and a detected break, and each one is cleared by its own clear input. The ageing timer measures how long characters have waited below the trigger level, so software can be told about a short message that will never reach the trigger. A soft reset returns the queue, the flags and the timer to their idle state without the global reset.

Top module: `uart_rx_buffer`

## Requirements
- R1: Stored words leave the queue in arrival order. When a pop request finds the queue non-empty, `pop_word` returns the oldest word with the valid marker (bit CHAR_W+5) set, and the queue holds at most DEPTH words. Word layout: bits CHAR_W-1:0 are the character, bit CHAR_W is the parity error, CHAR_W+1 the break, CHAR_W+2 the framing error, CHAR_W+3 the overrun tag, and CHAR_W+4 the error summary.
- R2: A pop request while the queue is empty returns an all-zero `pop_word` and leaves the fill count at zero.
- R3: A character accepted while DEPTH-1 words are already stored is stored with its overrun tag and its error summary bit set.
- R4: A character that arrives while the queue is full is discarded, the stored words stay unchanged, and `overrun_flag` becomes 1.
- R5: `rx_ready` sets on an arrival that leaves the fill count at or above `trig_level`. It clears on a pop that leaves the fill count below `trig_level`.
- R6: `data_ready` is 1 and `rx_empty` is 0 exactly while the queue holds at least one word. Every arrival sets `data_ready`, and a pop that empties the queue clears it.
- R7: The ageing timer counts only while the queue is non-empty and `rx_ready` is 0. When AGE_CYCLES clock cycles pass after the last restart, `age_flag` sets and stays set. While the queue is empty or `rx_ready` is 1, `age_flag` does not set.
- R8: Every arrival and every successful pop restarts the ageing timer from zero.
- R9: A break event (`rx_break`) stores a word with a zero character and with the break, framing-error and error-summary bits set, and it sets `break_flag`.
- R10: `clr_overrun`, `clr_age` and `clr_break` each clear their own sticky bit. If a set and a clear happen in the same cycle, the set wins.
- R11: `soft_rst` empties the queue, stops the timer, clears `rx_ready`, `data_ready` and the sticky bits, and sets `rx_empty`.
- R12: The parity and framing error flags of a character are stored with it, and either flag sets the word's error summary bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous return to the idle state |
| rx_valid | input | 1 | A received character is presented |
| rx_char | input | CHAR_W | Received character |
| rx_parity_err | input | 1 | Parity error flag of the character |
| rx_frame_err | input | 1 | Framing error flag of the character |
| rx_break | input | 1 | Line-break event; takes priority over rx_valid |
| trig_level | input | CNT_W | Receive-ready trigger level |
| pop_req | input | 1 | Remove the oldest word this cycle |
| clr_overrun | input | 1 | Clear the overrun sticky bit |
| clr_age | input | 1 | Clear the ageing sticky bit |
| clr_break | input | 1 | Clear the break sticky bit |
| pop_word | output | CHAR_W+6 | Oldest word with valid marker, or zero |
| fill_count | output | CNT_W | Number of stored words |
| rx_ready | output | 1 | Trigger level reached |
| data_ready | output | 1 | Queue holds data |
| rx_empty | output | 1 | Queue is empty |
| overrun_flag | output | 1 | Sticky overrun |
| age_flag | output | 1 | Sticky ageing timeout |
| break_flag | output | 1 | Sticky break detected |

## Verification
The bench builds the block with DEPTH=8, CHAR_W=8 and AGE_CYCLES=20. The short queue makes the last-slot tag and the full-queue drop reachable in a few pushes. The short ageing period allows exact edge-count checks of expiry on both sides of the deadline. With these values the restart-by-arrival, restart-by-pop and suppressed-while-ready timer cases all fit in a few hundred cycles. The trigger level is held at 4, halfway up the queue, so the fill count crosses it in both directions.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    // Flag positions inside a stored word, counted from the top of the character field
    localparam int FLAG_PAR  = 0;
    localparam int FLAG_BRK  = 1;
    localparam int FLAG_FRM  = 2;
    localparam int FLAG_OVR  = 3;
    localparam int FLAG_ERR  = 4;
    localparam int FLAG_RDY  = 5;
    localparam int FLAG_BITS = 6;

    typedef struct packed {
        logic rx_ready;
        logic data_ready;
        logic ovr;
        logic age;
        logic brk;
    } rxq_status_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int WIDTH = 13,
    parameter int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] head_data,
    output logic [CNT_W-1:0] fill
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t             s_d, s_q;
    logic [WIDTH-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else begin
            if (wr_en) s_d.wp = step(s_q.wp);
            if (rd_en) s_d.rp = step(s_q.rp);
            case ({wr_en, rd_en})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clear) mem[s_q.wp] <= wr_data;
    end

    assign head_data = mem[s_q.rp];
    assign fill      = s_q.cnt;
endmodule

// File: rtl/rxq_age.sv
module rxq_age #(
    parameter int AGE_CYCLES = 6944,
    localparam int TW = $clog2(AGE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic restart,
    input  logic run_ok,
    output logic expire,
    output logic armed
);
    typedef struct packed {
        logic          armed;
        logic [TW-1:0] tick;
    } age_t;

    age_t t_d, t_q;
    logic at_end;

    assign at_end = t_q.armed && (t_q.tick == TW'(AGE_CYCLES - 1));

    always_comb begin
        t_d = t_q;
        if (clear) begin
            t_d = '0;
        end else if (restart) begin
            t_d.armed = run_ok;
            t_d.tick  = '0;
        end else if (at_end) begin
            t_d = '0;
        end else if (t_q.armed) begin
            t_d.tick = t_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expire = at_end && !clear && !restart;
    assign armed  = t_q.armed;
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import rxq_pkg::*;
#(
    parameter int CHAR_W     = 8,
    parameter int DEPTH      = 32,
    parameter int AGE_CYCLES = 6944,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int WORD_W = CHAR_W + FLAG_BITS,
    localparam int STORE_W = WORD_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    input  logic              rx_break,
    input  logic [CNT_W-1:0]  trig_level,
    input  logic              pop_req,
    input  logic              clr_overrun,
    input  logic              clr_age,
    input  logic              clr_break,
    output logic [WORD_W-1:0] pop_word,
    output logic [CNT_W-1:0]  fill_count,
    output logic              rx_ready,
    output logic              data_ready,
    output logic              rx_empty,
    output logic              overrun_flag,
    output logic              age_flag,
    output logic              break_flag
);
    rxq_status_t        st_d, st_q;
    logic               push_evt, is_full, last_slot, wr_en, rd_en;
    logic               age_expire, age_armed, age_restart, age_run_ok;
    logic [CNT_W-1:0]   fill, fill_next;
    logic [STORE_W-1:0] in_word, head_word;
    logic               in_par, in_frm, in_ovr;

    assign push_evt  = rx_valid | rx_break;
    assign is_full   = (fill == CNT_W'(DEPTH));
    assign last_slot = (fill == CNT_W'(DEPTH - 1));
    assign wr_en     = push_evt && !is_full && !soft_rst;
    assign rd_en     = pop_req && (fill != '0) && !soft_rst;
    assign fill_next = fill + CNT_W'(wr_en) - CNT_W'(rd_en);

    // Incoming word; a break replaces the character with zero
    always_comb begin
        in_par = rx_parity_err && !rx_break;
        in_frm = rx_frame_err || rx_break;
        in_ovr = last_slot;
        in_word = '0;
        in_word[CHAR_W-1:0]       = rx_break ? '0 : rx_char;
        in_word[CHAR_W + FLAG_PAR] = in_par;
        in_word[CHAR_W + FLAG_BRK] = rx_break;
        in_word[CHAR_W + FLAG_FRM] = in_frm;
        in_word[CHAR_W + FLAG_OVR] = in_ovr;
        in_word[CHAR_W + FLAG_ERR] = in_par | in_frm | in_ovr;
    end

    rxq_store #(.WIDTH(STORE_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (soft_rst),
        .wr_en     (wr_en),
        .wr_data   (in_word),
        .rd_en     (rd_en),
        .head_data (head_word),
        .fill      (fill)
    );

    // Status flags: clears first so that a set in the same cycle wins
    always_comb begin
        st_d = st_q;
        if (clr_overrun) st_d.ovr = 1'b0;
        if (clr_age)     st_d.age = 1'b0;
        if (clr_break)   st_d.brk = 1'b0;
        if (push_evt) begin
            st_d.data_ready = 1'b1;
            if (fill_next >= trig_level) st_d.rx_ready = 1'b1;
            if (is_full)  st_d.ovr = 1'b1;
            if (rx_break) st_d.brk = 1'b1;
        end else if (rd_en) begin
            if (fill_next < trig_level) st_d.rx_ready = 1'b0;
            if (fill_next == '0)        st_d.data_ready = 1'b0;
        end
        if (age_expire) st_d.age = 1'b1;
        if (soft_rst)   st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign age_restart = push_evt | rd_en;
    assign age_run_ok  = (fill_next != '0) && !st_d.rx_ready;

    rxq_age #(.AGE_CYCLES(AGE_CYCLES)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (soft_rst),
        .restart (age_restart),
        .run_ok  (age_run_ok),
        .expire  (age_expire),
        .armed   (age_armed)
    );

    assign pop_word     = (pop_req && fill != '0) ? {1'b1, head_word} : '0;
    assign fill_count   = fill;
    assign rx_ready     = st_q.rx_ready;
    assign data_ready   = st_q.data_ready;
    assign rx_empty     = !st_q.data_ready;
    assign overrun_flag = st_q.ovr;
    assign age_flag     = st_q.age;
    assign break_flag   = st_q.brk;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int CHAR_W = 8,
    parameter int DEPTH  = 32,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int WORD_W = CHAR_W + 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              rx_valid,
    input logic              rx_break,
    input logic              pop_req,
    input logic [WORD_W-1:0] pop_word,
    input logic [CNT_W-1:0]  fill_count,
    input logic              rx_ready,
    input logic              rx_empty,
    input logic              overrun_flag,
    input logic              break_flag,
    input logic              age_armed
);
    p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    p_valid_marker_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && fill_count != '0) |-> pop_word[CHAR_W+5]);

    p_empty_pop_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && fill_count == '0) |-> (pop_word == '0));

    p_drop_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_valid || rx_break) && fill_count == CNT_W'(DEPTH) && !pop_req && !soft_rst)
        |=> (overrun_flag && fill_count == CNT_W'(DEPTH)));

    p_empty_matches_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty == (fill_count == '0));

    p_timer_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        age_armed |-> (fill_count != '0 && !rx_ready));

    p_break_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break && !soft_rst) |=> break_flag);

    p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (fill_count == '0 && rx_empty && !age_armed && !rx_ready));
endmodule

bind uart_rx_buffer rxq_checker #(.CHAR_W(CHAR_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .rx_valid     (rx_valid),
    .rx_break     (rx_break),
    .pop_req      (pop_req),
    .pop_word     (pop_word),
    .fill_count   (fill_count),
    .rx_ready     (rx_ready),
    .rx_empty     (rx_empty),
    .overrun_flag (overrun_flag),
    .break_flag   (break_flag),
    .age_armed    (age_armed)
);

// File: tb/uart_rx_buffer_bench.sv
module uart_rx_buffer_bench;
    localparam int CHAR_W = 8;
    localparam int DEPTH  = 8;
    localparam int AGE    = 20;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int WORD_W = CHAR_W + 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              soft_rst = 1'b0;
    logic              rx_valid = 1'b0;
    logic [CHAR_W-1:0] rx_char = '0;
    logic              rx_parity_err = 1'b0;
    logic              rx_frame_err = 1'b0;
    logic              rx_break = 1'b0;
    logic [CNT_W-1:0]  trig_level = CNT_W'(4);
    logic              pop_req = 1'b0;
    logic              clr_overrun = 1'b0;
    logic              clr_age = 1'b0;
    logic              clr_break = 1'b0;
    logic [WORD_W-1:0] pop_word;
    logic [CNT_W-1:0]  fill_count;
    logic              rx_ready, data_ready, rx_empty;
    logic              overrun_flag, age_flag, break_flag;

    int total = 0;
    int bad   = 0;
    int mcnt  = 0;
    logic [WORD_W-1:0] exp_q[$];
    logic [WORD_W-1:0] mon_exp;
    string             mon_tag = "R1";
    logic              pop_strobe = 1'b0;

    always #5 clk = ~clk;

    uart_rx_buffer #(.CHAR_W(CHAR_W), .DEPTH(DEPTH), .AGE_CYCLES(AGE)) u_uart_rx_buffer (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .rx_break(rx_break), .trig_level(trig_level),
        .pop_req(pop_req), .clr_overrun(clr_overrun), .clr_age(clr_age),
        .clr_break(clr_break), .pop_word(pop_word), .fill_count(fill_count),
        .rx_ready(rx_ready), .data_ready(data_ready), .rx_empty(rx_empty),
        .overrun_flag(overrun_flag), .age_flag(age_flag), .break_flag(break_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares every popped word against the scoreboard queue
    always @(posedge pop_strobe) begin
        mon_exp = (exp_q.size() == 0) ? '0 : exp_q.pop_front();
        check(mon_tag, 32'(pop_word), 32'(mon_exp));
    end

    function automatic logic [WORD_W-1:0] mk(input logic [7:0] ch, input logic par,
                                             input logic brk, input logic frm, input logic ovr);
        return {1'b1, par | frm | ovr, ovr, frm, brk, par, ch};
    endfunction

    task automatic push_char(input logic [7:0] ch, input logic par, input logic frm);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = ch; rx_parity_err = par; rx_frame_err = frm;
        if (mcnt < DEPTH) begin
            exp_q.push_back(mk(ch, par, 1'b0, frm, mcnt == DEPTH - 1));
            mcnt++;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_parity_err = 1'b0; rx_frame_err = 1'b0;
    endtask

    task automatic push_break();
        @(negedge clk);
        rx_break = 1'b1;
        if (mcnt < DEPTH) begin
            exp_q.push_back(mk(8'h00, 1'b0, 1'b1, 1'b1, mcnt == DEPTH - 1));
            mcnt++;
        end
        @(negedge clk);
        rx_break = 1'b0;
    endtask

    task automatic pop_one(input string tag);
        @(negedge clk);
        mon_tag = tag; pop_req = 1'b1;
        #1 pop_strobe = 1'b1;
        @(negedge clk);
        pop_req = 1'b0; pop_strobe = 1'b0;
        if (mcnt > 0) mcnt--;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clear(input logic ov, input logic ag, input logic bk);
        @(negedge clk);
        clr_overrun = ov; clr_age = ag; clr_break = bk;
        @(negedge clk);
        clr_overrun = 1'b0; clr_age = 1'b0; clr_break = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R6 reset rx_empty", 32'(rx_empty), 1);
        check("R6 reset data_ready", 32'(data_ready), 0);
        check("R1 reset fill", 32'(fill_count), 0);
        check("R5 reset rx_ready", 32'(rx_ready), 0);
        check("R10 reset stickies", {29'd0, overrun_flag, age_flag, break_flag}, 0);

        // R2: pop of an empty queue
        pop_one("R2 empty pop word");
        check("R2 fill after empty pop", 32'(fill_count), 0);

        // R7: three characters below trigger, timer expires after AGE cycles
        push_char(8'h41, 0, 0);
        push_char(8'h42, 0, 0);
        push_char(8'h43, 0, 0);
        check("R5 below trigger", 32'(rx_ready), 0);
        check("R6 data_ready set", 32'(data_ready), 1);
        wait_edges(AGE - 1);
        check("R7 age before deadline", 32'(age_flag), 0);
        wait_edges(1);
        check("R7 age at deadline", 32'(age_flag), 1);

        // R8: restart by arrival
        pulse_clear(0, 1, 0);
        check("R10 age cleared", 32'(age_flag), 0);
        pop_one("R1 order");
        wait_edges(AGE - 5);
        push_char(8'h44, 0, 0);
        wait_edges(AGE - 1);
        check("R8 push restart before", 32'(age_flag), 0);
        wait_edges(1);
        check("R8 push restart at", 32'(age_flag), 1);

        // R8: restart by pop
        pulse_clear(0, 1, 0);
        pop_one("R1 order");
        wait_edges(AGE - 5);
        pop_one("R1 order");
        wait_edges(AGE - 1);
        check("R8 pop restart before", 32'(age_flag), 0);
        wait_edges(1);
        check("R8 pop restart at", 32'(age_flag), 1);

        // R5/R7: reach trigger, timer suppressed
        push_char(8'h45, 0, 0);
        push_char(8'h46, 0, 0);
        check("R5 count 3 not ready", 32'(rx_ready), 0);
        push_char(8'h47, 0, 0);
        check("R5 at trigger", 32'(rx_ready), 1);
        pulse_clear(0, 1, 0);
        wait_edges(2 * AGE);
        check("R7 no age while ready", 32'(age_flag), 0);
        pop_one("R1 order");
        check("R5 below trigger after pop", 32'(rx_ready), 0);
        pop_one("R1 order");
        pop_one("R1 order");
        pop_one("R1 order");
        check("R6 empty after drain data_ready", 32'(data_ready), 0);
        check("R6 empty after drain rx_empty", 32'(rx_empty), 1);
        check("R1 fill after drain", 32'(fill_count), 0);

        // R3/R4: fill to the top, tag last slot, drop the next
        for (int i = 0; i < DEPTH; i++) push_char(8'(i * 37 + 5), 0, 0);
        check("R1 fill full", 32'(fill_count), DEPTH);
        check("R4 no overrun yet", 32'(overrun_flag), 0);
        push_char(8'hEE, 0, 0);
        check("R4 overrun sticky", 32'(overrun_flag), 1);
        check("R4 fill unchanged", 32'(fill_count), DEPTH);
        for (int i = 0; i < DEPTH - 1; i++) pop_one("R1 order full");
        pop_one("R3 last slot tag");
        check("R6 empty after full drain", 32'(rx_empty), 1);

        // R12: error flags
        push_char(8'h5A, 1, 0);
        push_char(8'hA5, 0, 1);
        push_char(8'h3C, 1, 1);
        pop_one("R12 parity word");
        pop_one("R12 frame word");
        pop_one("R12 both flags word");

        // R9: break event
        push_break();
        check("R9 break sticky", 32'(break_flag), 1);
        pop_one("R9 break word");

        // R10: clear stickies, queue empty so timer stays stopped
        pulse_clear(1, 1, 1);
        check("R10 overrun cleared", 32'(overrun_flag), 0);
        check("R10 break cleared", 32'(break_flag), 0);
        wait_edges(AGE + 2);
        check("R7 no age when empty", 32'(age_flag), 0);

        // R11: soft reset
        push_char(8'h11, 0, 0);
        push_break();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        exp_q.delete();
        mcnt = 0;
        check("R11 fill cleared", 32'(fill_count), 0);
        check("R11 rx_empty set", 32'(rx_empty), 1);
        check("R11 break cleared", 32'(break_flag), 0);
        wait_edges(AGE + 2);
        check("R11 timer stopped", 32'(age_flag), 0);
        pop_one("R11 pop after soft reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule